// File: doc/BRIEF.md
# Dual-Mode SPI Register Slave

This block is the serial front end of a 256-byte register file. A host reaches the registers over SPI through one address pointer. The pointer lives in the slave, advances on its own after every data byte and survives across chip-select frames. A frame starts with a command byte. That byte either loads the pointer from the byte after it, opens a write stream or opens a read stream. Any other opcode silences the slave until chip select rises again.

A static configuration input selects one of two wire modes. In full-duplex mode the host sends on MOSI and the slave answers on MISO at the same time. While the command byte arrives, MISO already carries the byte at the current pointer. In shared-pin mode a single data pin carries both directions. The host drives it for the command byte. On a read command, the slave takes the pin after the eighth clock and keeps it for the rest of the frame.

The SPI pins are oversampled by the system clock, so all logic runs in one clock domain. The register file is outside the block. It presents read data combinationally for the address the block drives, and it accepts a one-cycle write strobe.

Top module: `spi_reg_slave`

## Requirements
- R1: While chip select (`cs_n`) is high, `miso_oe` and `sio_oe` are both low, and they are low after reset.
- R2: Bytes travel MSB first in SPI mode 0. The slave samples on the rising SCLK edge and changes its output bit only after a falling edge.
- R3: Command 0x7D loads the address pointer with the next complete byte. The slave then expects a new command byte in the same frame.
- R4: After command 0x7E, each complete following byte is written to the register at the pointer, and the pointer then advances by one.
- R5: After command 0x7F, each following byte the slave sends is the register at the pointer, fetched before its first bit goes out. The pointer advances by one after each such byte.
- R6: The pointer wraps from 0xFF to 0x00 on reads and on writes.
- R7: The pointer value is kept across chip-select deassertion. The bit counter and the command state restart at every new frame.
- R8: A byte cut short by chip select rising causes no register write and no pointer change.
- R9: Any opcode other than 0x7D, 0x7E or 0x7F causes no write and no pointer change. The slave outputs zero bits for the rest of that frame.
- R10: In full-duplex mode (`bidir_mode`=0), `miso_oe` is high while the slave is selected. During the command byte, MISO carries the register at the current pointer.
- R11: In shared-pin mode (`bidir_mode`=1), `miso_oe` stays low. `sio_oe` is low during command, pointer and write bytes. It is high during the data bytes that follow a 0x7F command.
- R12: `reg_we` is a single-cycle strobe, asserted exactly once per completed write byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| bidir_mode | input | 1 | 0: full duplex on MOSI/MISO, 1: shared data pin |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | SPI clock from the host |
| mosi | input | 1 | Host-to-slave data in full-duplex mode |
| miso | output | 1 | Slave-to-host data in full-duplex mode |
| miso_oe | output | 1 | Output enable for MISO |
| sio_i | input | 1 | Shared data pin, input side |
| sio_o | output | 1 | Shared data pin, output side |
| sio_oe | output | 1 | Output enable for the shared data pin |
| reg_addr | output | 8 | Register address, equal to the pointer |
| reg_rdata | input | 8 | Register read data for `reg_addr` |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe |

## Verification
Each SPI pin passes two synchronizer flops. As a result, a sampled bit enters the shift register about three system clocks after its SCLK edge. A completed write reaches `reg_we` about four clocks after the eighth rising edge. The next outgoing byte is loaded one clock after that. Output bits move about three clocks after each falling edge. The bench holds each SCLK half-period for eight system clocks and samples the slave's output at the end of the low half, so every result is settled well before it is read. Register contents and strobe counts are checked only after chip select has been high for a dozen clocks.

// File: rtl/spi_rs_pkg.sv
// Shared constants and types of the dual-mode SPI register slave.
// Assumes byte-wide commands and data.
package spi_rs_pkg;
    localparam int BYTE_W = 8;

    // Command opcodes recognised in the first byte of a frame
    localparam logic [BYTE_W-1:0] OP_SETPTR = 8'h7D;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h7E;
    localparam logic [BYTE_W-1:0] OP_READ   = 8'h7F;

    // Frame state: what the next completed byte means
    typedef enum logic [2:0] {
        PH_CMD,
        PH_SETPTR,
        PH_WRITE,
        PH_READ,
        PH_IGNORE
    } phase_t;
endpackage

// File: rtl/spi_rs_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is independent (no bus coherence needed) and STAGES >= 2.
module spi_rs_sync #(
    parameter int              N       = 4,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the pin value through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
                else        chain <= {chain[STAGES-2:0], d_async[i]};
            end
            assign d_sync[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_rs_shifter.sv
// Mode-0 bit engine: samples on SCLK rise, shifts output after SCLK fall,
// counts bits and flags each completed byte for one clock.
// Assumes edge pulses are single-cycle and a load never lands on a rise.
module spi_rs_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         din,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] rx_byte,
    output logic         byte_done,
    output logic         dout
);
    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     tx_sh;
    logic             done_q;

    // Receive shift, bit count and byte-complete flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            done_q  <= 1'b0;
        end else if (!sel) begin
            bit_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (sclk_rise) begin
                rx_sh   <= {rx_sh[W-2:0], din};
                bit_cnt <= (bit_cnt == CNT_W'(W-1)) ? '0 : bit_cnt + 1'b1;
                done_q  <= (bit_cnt == CNT_W'(W-1));
            end
        end
    end

    // Transmit register: load at byte boundary, shift after mid-byte falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (!sel) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_val;
        end else if (sclk_fall && bit_cnt != '0) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
        end
    end

    assign rx_byte   = rx_sh;
    assign byte_done = done_q;
    assign dout      = tx_sh[W-1];
endmodule

// File: rtl/spi_rs_ctrl.sv
// Command decoder and address pointer. Turns completed bytes into pointer
// loads, register writes and read fetches; picks the next outgoing byte.
// Assumes AW <= BYTE_W and a combinational register-file read.
module spi_rs_ctrl
    import spi_rs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sel_start,
    input  logic              bidir,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [AW-1:0]     ptr,
    output logic              reg_we,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              load,
    output logic [BYTE_W-1:0] load_val,
    output logic              read_drive
);
    phase_t  phase;
    logic    load_q;
    logic    fetch_en;

    // Frame phase and pointer update on each completed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CMD;
            ptr   <= '0;
        end else if (!sel) begin
            phase <= PH_CMD;
        end else if (byte_done) begin
            case (phase)
                PH_CMD: begin
                    if (rx_byte == OP_SETPTR)     phase <= PH_SETPTR;
                    else if (rx_byte == OP_WRITE) phase <= PH_WRITE;
                    else if (rx_byte == OP_READ)  phase <= PH_READ;
                    else                          phase <= PH_IGNORE;
                end
                PH_SETPTR: begin
                    ptr   <= AW'(rx_byte);
                    phase <= PH_CMD;
                end
                PH_WRITE: ptr <= ptr + 1'b1;
                PH_READ:  ptr <= ptr + 1'b1;
                default:  phase <= phase;
            endcase
        end
    end

    // Request a transmit load at frame start and after each byte boundary
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= sel_start | (sel & byte_done);
    end

    // Fetch the pointed-to register for read data or full-duplex echo
    always_comb begin
        fetch_en = (phase == PH_READ) || (phase == PH_CMD && !bidir);
        load_val = fetch_en ? reg_rdata : '0;
    end

    assign reg_we     = sel & byte_done & (phase == PH_WRITE);
    assign reg_wdata  = rx_byte;
    assign load       = load_q;
    assign read_drive = (phase == PH_READ);
endmodule

// File: rtl/spi_reg_slave.sv
// Top of the dual-mode SPI register slave. Synchronizes the pins, detects
// SCLK edges, and steers data between the pins and the bit engine.
// Assumes SCLK runs well below a quarter of clk and bidir_mode only
// changes while cs_n is high.
module spi_reg_slave
    import spi_rs_pkg::*;
#(
    parameter int AW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bidir_mode,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              sio_i,
    output logic              sio_o,
    output logic              sio_oe,
    output logic [AW-1:0]     reg_addr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we
);
    localparam int NPIN = 4;

    logic [NPIN-1:0]   pins_s;
    logic              cs_n_s, sclk_s, mosi_s, sio_s;
    logic              sclk_q, sel_q;
    logic              sel, sel_start, sclk_rise, sclk_fall, din;
    logic              load, byte_done, dout, read_drive;
    logic [BYTE_W-1:0] load_val, rx_byte;

    spi_rs_sync #(
        .N       (NPIN),
        .STAGES  (SYNC_STGS),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sio_i, mosi, sclk, cs_n}),
        .d_sync  (pins_s)
    );

    assign {sio_s, mosi_s, sclk_s, cs_n_s} = pins_s;

    // Previous SCLK and select levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            sel_q  <= sel;
        end
    end

    assign sel       = ~cs_n_s;
    assign sel_start = sel & ~sel_q;
    assign sclk_rise = sel & sclk_s & ~sclk_q;
    assign sclk_fall = sel & ~sclk_s & sclk_q;
    assign din       = bidir_mode ? sio_s : mosi_s;

    spi_rs_shifter #(
        .W (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din),
        .load      (load),
        .load_val  (load_val),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .dout      (dout)
    );

    spi_rs_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sel_start  (sel_start),
        .bidir      (bidir_mode),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .reg_rdata  (reg_rdata),
        .ptr        (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .load       (load),
        .load_val   (load_val),
        .read_drive (read_drive)
    );

    // Pin direction and data steering per wire mode
    always_comb begin
        miso_oe = sel & ~bidir_mode;
        sio_oe  = sel & bidir_mode & read_drive;
        miso    = miso_oe & dout;
        sio_o   = sio_oe & dout;
    end
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Property checker for spi_reg_slave, attached by bind.
// Assumes the synchronizer depth is at most three flops.
module spi_reg_slave_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bidir_mode,
    input logic          cs_n,
    input logic          miso_oe,
    input logic          sio_oe,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!miso_oe && !sio_oe)); // R1

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R12

    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + 1'b1)); // R4

    AST_PTR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |=> $stable(reg_addr)); // R7

    AST_SHARED_NO_MISO: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode |-> !miso_oe); // R11

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({miso_oe, sio_oe}) <= 1); // R11

    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> !reg_we); // R11
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bidir_mode (bidir_mode),
    .cs_n       (cs_n),
    .miso_oe    (miso_oe),
    .sio_oe     (sio_oe),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr)
);

// File: tb/spi_reg_slave_tb_top.sv
// Directed bench for spi_reg_slave: one task per scenario, each checking
// its own results against values derived from the requirements.
module spi_reg_slave_tb_top;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bidir_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       sio_i = 1'b0;
    logic       miso, miso_oe, sio_o, sio_oe, reg_we;
    logic [7:0] reg_addr, reg_rdata, reg_wdata;

    logic [7:0] mem [256];
    int         we_cnt = 0;
    int         n_chk = 0;
    int         n_err = 0;
    logic       oe_any, oe_all;

    always #5 clk = ~clk;

    spi_reg_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bidir_mode (bidir_mode),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .mosi       (mosi),
        .miso       (miso),
        .miso_oe    (miso_oe),
        .sio_i      (sio_i),
        .sio_o      (sio_o),
        .sio_oe     (sio_oe),
        .reg_addr   (reg_addr),
        .reg_rdata  (reg_rdata),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we)
    );

    // Bench register file with combinational read
    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        idle(HP);
    endtask

    task automatic cs_hi();
        idle(HP);
        cs_n = 1'b1;
        idle(12);
    endtask

    // Move nbits of one byte, MSB first; sample the slave output before each rise
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
        rx = '0;
        oe_any = 1'b0;
        oe_all = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            mosi  = tx[7-i];
            sio_i = tx[7-i];
            idle(HP);
            rx[7-i] = bidir_mode ? sio_o : miso;
            oe_any  = oe_any | sio_oe;
            oe_all  = oe_all & sio_oe;
            sclk = 1'b1;
            idle(HP);
            sclk = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 miso_oe after reset", int'(miso_oe), 0);
        check("R1 sio_oe after reset", int'(sio_oe), 0);
        check("R12 no strobe at reset", int'(reg_we), 0);
    endtask

    task automatic t_fd_write();
        logic [7:0] r;
        int w0 = we_cnt;
        cs_lo();
        xfer(8'h7D, r); xfer(8'h10, r);
        xfer(8'h7E, r); xfer(8'h11, r); xfer(8'h22, r);
        cs_hi();
        check("R3 R4 write at loaded pointer", int'(mem[8'h10]), 'h11);
        check("R4 write after increment", int'(mem[8'h11]), 'h22);
        check("R12 one strobe per byte", we_cnt - w0, 2);
    endtask

    task automatic t_fd_read();
        logic [7:0] r;
        cs_lo();
        xfer(8'h7D, r); xfer(8'h10, r);
        xfer(8'h7F, r);
        xfer(8'h00, r); check("R2 R5 read byte 0", int'(r), 'h11);
        xfer(8'h00, r); check("R5 read byte 1", int'(r), 'h22);
        xfer(8'h00, r); check("R5 read byte 2", int'(r), int'(init_val('h12)));
        cs_hi();
    endtask

    task automatic t_persist();
        logic [7:0] r;
        cs_lo();
        xfer(8'h7F, r);
        xfer(8'h00, r); check("R7 pointer kept across frames", int'(r), int'(init_val('h13)));
        cs_hi();
    endtask

    task automatic t_cmd_echo();
        logic [7:0] r;
        cs_lo();
        xfer(8'h7D, r); xfer(8'h40, r);
        cs_hi();
        cs_lo();
        check("R10 miso_oe while selected", int'(miso_oe), 1);
        xfer(8'h7F, r); check("R10 echo during command", int'(r), int'(init_val('h40)));
        xfer(8'h00, r); check("R5 first read byte", int'(r), int'(init_val('h40)));
        cs_hi();
        check("R1 miso_oe released", int'(miso_oe), 0);
    endtask

    task automatic t_wrap_read();
        logic [7:0] r;
        cs_lo();
        xfer(8'h7D, r); xfer(8'hFE, r);
        xfer(8'h7F, r);
        xfer(8'h00, r); check("R6 read FE", int'(r), int'(init_val('hFE)));
        xfer(8'h00, r); check("R6 read FF", int'(r), int'(init_val('hFF)));
        xfer(8'h00, r); check("R6 read wraps to 00", int'(r), int'(init_val('h00)));
        cs_hi();
    endtask

    task automatic t_wrap_write();
        logic [7:0] r;
        cs_lo();
        xfer(8'h7D, r); xfer(8'hFF, r);
        xfer(8'h7E, r); xfer(8'h5A, r); xfer(8'h6B, r);
        cs_hi();
        check("R6 write FF", int'(mem[8'hFF]), 'h5A);
        check("R6 write wraps to 00", int'(mem[8'h00]), 'h6B);
    endtask

    task automatic t_ignored();
        logic [7:0] r;
        int w0 = we_cnt;
        cs_lo();
        xfer(8'h7D, r); xfer(8'h20, r);
        xfer(8'h55, r);
        xfer(8'h99, r); check("R9 zeros after bad opcode", int'(r), 0);
        xfer(8'h7E, r); check("R9 still zeros", int'(r), 0);
        cs_hi();
        check("R9 no write", we_cnt - w0, 0);
        check("R9 register untouched", int'(mem[8'h20]), int'(init_val('h20)));
        cs_lo();
        xfer(8'h7F, r);
        xfer(8'h00, r); check("R9 pointer unchanged", int'(r), int'(init_val('h20)));
        cs_hi();
    endtask

    task automatic t_partial();
        logic [7:0] r;
        int w0 = we_cnt;
        cs_lo();
        xfer(8'h7D, r); xfer(8'h30, r);
        xfer(8'h7E, r);
        xfer(8'hC3, r, 4);
        cs_hi();
        check("R8 no write on short byte", we_cnt - w0, 0);
        check("R8 register untouched", int'(mem[8'h30]), int'(init_val('h30)));
        cs_lo();
        xfer(8'h7F, r);
        xfer(8'h00, r); check("R8 R7 pointer and counter restart", int'(r), int'(init_val('h30)));
        cs_hi();
    endtask

    task automatic t_bidir_read();
        logic [7:0] r;
        bidir_mode = 1'b1;
        idle(4);
        cs_lo();
        check("R11 miso_oe low in shared mode", int'(miso_oe), 0);
        xfer(8'h7D, r); xfer(8'h50, r);
        xfer(8'h7F, r); check("R11 pin released in command", int'(oe_any), 0);
        xfer(8'h00, r);
        check("R11 pin driven in read data", int'(oe_all), 1);
        check("R5 R11 shared-pin read", int'(r), int'(init_val('h50)));
        cs_hi();
        check("R1 sio_oe released", int'(sio_oe), 0);
    endtask

    task automatic t_bidir_write();
        logic [7:0] r;
        cs_lo();
        xfer(8'h7D, r); xfer(8'h60, r);
        xfer(8'h7E, r); xfer(8'hE1, r);
        check("R11 pin released on write", int'(oe_any), 0);
        cs_hi();
        check("R4 R11 shared-pin write", int'(mem[8'h60]), 'hE1);
        bidir_mode = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_fd_write();
        t_fd_read();
        t_persist();
        t_cmd_echo();
        t_wrap_read();
        t_wrap_write();
        t_ignored();
        t_partial();
        t_bidir_read();
        t_bidir_write();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule